// File: doc/BRIEF.md
# Configuration Space Register File

This block holds the 256-byte configuration space of a bus agent. A bus controller hands it the address phase of every bus cycle. The block claims a cycle only when the agent's private select line is high and the cycle is a type-0 configuration read or write. The block does not claim by address match, because the agent has no assigned address window until software has programmed its base register.

The space has two parts. The 64-byte header holds the identity fields, which are fixed by parameters. It also holds the command bits, one memory base register whose low bits report the window size, and the interrupt routing byte. The remaining 192 bytes are plain storage that driver software can read and write. Every write is filtered by four active-low byte-lane enables.

The programmed base address and two command enables are brought out to the rest of the agent. Bus handshaking is the controller's job and is not part of this block.

Top module: `cfg_space_regs`

## Requirements
- R1: In a cycle with `cfg_addr_valid` high, `cfg_claim` is high exactly when `cfg_idsel` is 1, `cfg_cmd` is 4'b1010 (configuration read) or 4'b1011 (configuration write), and `cfg_addr[1:0]` is 2'b00. `cfg_claim` is low in every other cycle.
- R2: An address phase that is not claimed leaves all register state unchanged through the data strobe that follows it. This covers `cfg_addr[1:0]` = 2'b01 (type 1), other commands, and `cfg_idsel` low.
- R3: `cfg_addr[7:2]` selects a 32-bit word. Words 0 to 15 (bytes 00h to 3Fh) are the header. Words 16 to 63 (bytes 40h to FFh) are general storage that reads back what was last written.
- R4: Fixed fields read as parameters and cannot be written. Word 0 reads {DEVICE_ID, VENDOR_ID}. Word 2 reads {CLASS_CODE[23:0], REVISION_ID}. Word 3 reads HEADER_TYPE in bits 23:16. Word 15 reads INT_PIN in bits 15:8.
- R5: Byte enables are active low. `cfg_be_n[n]` = 0 lets a write change bits 8n+7:8n, and `cfg_be_n[n]` = 1 protects them. This applies to every writable field.
- R6: Word 4 is the memory base register. Bits below BAR_SIZE_LOG2 always read 0. Bits from BAR_SIZE_LOG2 up are writable. Writing all ones therefore reads back the size mask, and the register's value appears on `bar_base`.
- R7: In word 1, bit 1 (memory enable) and bit 6 (parity error response) are writable and drive `mem_en` and `perr_en`. All other bits of word 1, including the status half, read 0.
- R8: Word 15 bits 7:0 (interrupt line) are writable. Words 5 to 14, and all bits not listed in R4, R6, R7 and R8, read 0 and ignore writes.
- R9: After reset, `mem_en`, `perr_en`, `bar_base`, the interrupt line and all general storage are 0.
- R10: The data strobe of a claimed read cycle changes no state.
- R11: During the data strobe of a claimed cycle, `cfg_rdata` shows the current value of the selected word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr_valid | input | 1 | Address phase strobe |
| cfg_idsel | input | 1 | Per-agent configuration select |
| cfg_cmd | input | 4 | Command code in the address phase |
| cfg_addr | input | 8 | Low address byte: [7:2] word, [1:0] format |
| cfg_dat_valid | input | 1 | Data phase strobe |
| cfg_wdata | input | 32 | Write data |
| cfg_be_n | input | 4 | Active-low byte-lane enables |
| cfg_claim | output | 1 | Cycle claimed (address phase) |
| cfg_rdata | output | 32 | Read data of the selected word |
| bar_base | output | 32 | Programmed memory window base |
| mem_en | output | 1 | Memory space enable |
| perr_en | output | 1 | Parity error response enable |

## Verification
The bench targets these corner cases:
- A type-1 format or a non-configuration command while the select line is high. A design that looked only at the select line would claim these cycles and corrupt registers.
- A select line that is low on a valid configuration command. A design that decoded the command without the select line would claim the cycle.
- BAR sizing with all ones, and writes with partial byte enables. A design that ignored the size mask would read back ones in the low bits. A design that ignored a byte lane would overwrite a protected byte.
- Writes to the identity, status and unused words, and the data strobe of a read cycle. In a faulty design these would change read-only values or leak into neighbouring storage.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;
   localparam logic [3:0] CMD_CFG_RD = 4'b1010;
   localparam logic [3:0] CMD_CFG_WR = 4'b1011;
   localparam int IDX_W      = 6;
   localparam int HDR_WORDS  = 16;
   localparam logic [IDX_W-1:0] W_IDENT = 6'd0;
   localparam logic [IDX_W-1:0] W_CMD   = 6'd1;
   localparam logic [IDX_W-1:0] W_CLASS = 6'd2;
   localparam logic [IDX_W-1:0] W_MISC  = 6'd3;
   localparam logic [IDX_W-1:0] W_BAR   = 6'd4;
   localparam logic [IDX_W-1:0] W_INTR  = 6'd15;

   function automatic logic [31:0] lane_mask(input logic [3:0] be_n);
      logic [31:0] m;
      for (int i = 0; i < 4; i++) m[8*i +: 8] = be_n[i] ? 8'h00 : 8'hFF;
      return m;
   endfunction
endpackage

// File: rtl/cfg_space_decode.sv
module cfg_space_decode
   import cfg_space_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             addr_valid,
   input  logic             idsel,
   input  logic [3:0]       cmd,
   input  logic [7:0]       addr,
   input  logic             dat_valid,
   output logic             claim,
   output logic             wr_en,
   output logic [IDX_W-1:0] idx
);
   logic act_q, wr_q;
   logic cmd_ok, fmt0;

   assign cmd_ok = (cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR);
   assign fmt0   = (addr[1:0] == 2'b00);
   assign claim  = addr_valid & idsel & cmd_ok & fmt0;
   assign wr_en  = dat_valid & act_q & wr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         wr_q  <= 1'b0;
         idx   <= '0;
      end else if (addr_valid) begin
         act_q <= claim;
         wr_q  <= cmd[0];
         idx   <= addr[7:2];
      end else if (dat_valid) begin
         act_q <= 1'b0;
      end
   end

   // R2: a cycle in type-1 format or without select never enables a write
   assert_unclaimed_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid && (!idsel || addr[1:0] != 2'b00) |=> !wr_en);
   // R10: the data strobe of a read cycle never writes
   assert_read_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid && idsel && cmd == CMD_CFG_RD && fmt0 |=> !wr_en);
endmodule

// File: rtl/cfg_space_header.sv
module cfg_space_header
   import cfg_space_pkg::*;
#(
   parameter logic [15:0] VENDOR_ID     = 16'h1A2B,
   parameter logic [15:0] DEVICE_ID     = 16'h3C4D,
   parameter logic [7:0]  REVISION_ID   = 8'h05,
   parameter logic [23:0] CLASS_CODE    = 24'h0B4000,
   parameter logic [7:0]  HEADER_TYPE   = 8'h00,
   parameter logic [7:0]  INT_PIN       = 8'h01,
   parameter int          BAR_SIZE_LOG2 = 12
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] idx,
   input  logic [31:0]      wdata,
   input  logic [3:0]       be_n,
   output logic [31:0]      rdata,
   output logic [31:0]      bar_base,
   output logic             mem_en,
   output logic             perr_en
);
   localparam int          BAR_W    = 32 - BAR_SIZE_LOG2;
   localparam logic [31:0] BAR_MASK = ~((32'd1 << BAR_SIZE_LOG2) - 32'd1);

   logic [BAR_W-1:0] bar_q;
   logic [7:0]       int_line_q;
   logic [31:0]      lanes, bar_next;

   assign lanes    = lane_mask(be_n);
   assign bar_next = (bar_base & ~lanes) | (wdata & lanes);

   generate
      if (BAR_SIZE_LOG2 == 31) begin : g_bar_top
         assign bar_base = {bar_q, 31'd0};
      end else begin : g_bar_mid
         assign bar_base = {bar_q, {BAR_SIZE_LOG2{1'b0}}};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bar_q      <= '0;
         int_line_q <= '0;
         mem_en     <= 1'b0;
         perr_en    <= 1'b0;
      end else if (wr_en) begin
         if (idx == W_BAR) bar_q <= bar_next[31:BAR_SIZE_LOG2];
         if (idx == W_CMD && !be_n[0]) begin
            mem_en  <= wdata[1];
            perr_en <= wdata[6];
         end
         if (idx == W_INTR && !be_n[0]) int_line_q <= wdata[7:0];
      end
   end

   always_comb begin
      case (idx)
         W_IDENT: rdata = {DEVICE_ID, VENDOR_ID};
         W_CMD:   rdata = {25'd0, perr_en, 4'd0, mem_en, 1'b0};
         W_CLASS: rdata = {CLASS_CODE, REVISION_ID};
         W_MISC:  rdata = {8'd0, HEADER_TYPE, 16'd0};
         W_BAR:   rdata = bar_base;
         W_INTR:  rdata = {16'd0, INT_PIN, int_line_q};
         default: rdata = 32'd0;
      endcase
   end

   // R6: a full write of the base register loads the bits above the size
   assert_bar_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && idx == W_BAR && be_n == 4'b0000 |=> bar_base == ($past(wdata) & BAR_MASK));
   // R5: a disabled top lane keeps the top byte of the base register
   assert_lane_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && idx == W_BAR && be_n[3] |=> bar_base[31:24] == $past(bar_base[31:24]));
   // R7: command enables follow the written bits
   assert_cmd_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && idx == W_CMD && !be_n[0] |=> mem_en == $past(wdata[1]) && perr_en == $past(wdata[6]));
   // R8: enables change only through a command write
   assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && idx == W_CMD) |=> $stable(mem_en) && $stable(perr_en));
endmodule

// File: rtl/cfg_space_user.sv
module cfg_space_user
   import cfg_space_pkg::*;
#(
   parameter int USER_WORDS = 48
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] idx,
   input  logic [31:0]      wdata,
   input  logic [3:0]       be_n,
   output logic [31:0]      rdata
);
   logic [31:0]      words [USER_WORDS];
   logic [IDX_W-1:0] uidx;
   logic [31:0]      lanes;

   assign uidx  = idx - IDX_W'(HDR_WORDS);
   assign lanes = lane_mask(be_n);

   for (genvar k = 0; k < USER_WORDS; k++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) words[k] <= '0;
         else if (wr_en && uidx == IDX_W'(k))
            words[k] <= (words[k] & ~lanes) | (wdata & lanes);
      end
   end

   always_comb begin
      rdata = 32'd0;
      for (int k = 0; k < USER_WORDS; k++)
         if (uidx == IDX_W'(k)) rdata = words[k];
   end
endmodule

// File: rtl/cfg_space_regs.sv
module cfg_space_regs
   import cfg_space_pkg::*;
#(
   parameter logic [15:0] VENDOR_ID     = 16'h1A2B,
   parameter logic [15:0] DEVICE_ID     = 16'h3C4D,
   parameter logic [7:0]  REVISION_ID   = 8'h05,
   parameter logic [23:0] CLASS_CODE    = 24'h0B4000,
   parameter logic [7:0]  HEADER_TYPE   = 8'h00,
   parameter logic [7:0]  INT_PIN       = 8'h01,
   parameter int          BAR_SIZE_LOG2 = 12,
   parameter int          USER_WORDS    = 48
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_addr_valid,
   input  logic        cfg_idsel,
   input  logic [3:0]  cfg_cmd,
   input  logic [7:0]  cfg_addr,
   input  logic        cfg_dat_valid,
   input  logic [31:0] cfg_wdata,
   input  logic [3:0]  cfg_be_n,
   output logic        cfg_claim,
   output logic [31:0] cfg_rdata,
   output logic [31:0] bar_base,
   output logic        mem_en,
   output logic        perr_en
);
   if (BAR_SIZE_LOG2 < 4 || BAR_SIZE_LOG2 > 31) begin : g_bad_bar
      $error("BAR_SIZE_LOG2 must lie in 4..31");
   end
   if (USER_WORDS < 1 || USER_WORDS > 48) begin : g_bad_user
      $error("USER_WORDS must lie in 1..48");
   end

   logic             wr_en, hdr_sel;
   logic [IDX_W-1:0] idx;
   logic [31:0]      hdr_rdata, usr_rdata;

   assign hdr_sel = (idx < IDX_W'(HDR_WORDS));

   cfg_space_decode u_decode (
      .clk(clk), .rst_n(rst_n), .addr_valid(cfg_addr_valid), .idsel(cfg_idsel),
      .cmd(cfg_cmd), .addr(cfg_addr), .dat_valid(cfg_dat_valid),
      .claim(cfg_claim), .wr_en(wr_en), .idx(idx));

   cfg_space_header #(
      .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .REVISION_ID(REVISION_ID),
      .CLASS_CODE(CLASS_CODE), .HEADER_TYPE(HEADER_TYPE), .INT_PIN(INT_PIN),
      .BAR_SIZE_LOG2(BAR_SIZE_LOG2)
   ) u_header (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en & hdr_sel), .idx(idx),
      .wdata(cfg_wdata), .be_n(cfg_be_n), .rdata(hdr_rdata),
      .bar_base(bar_base), .mem_en(mem_en), .perr_en(perr_en));

   cfg_space_user #(.USER_WORDS(USER_WORDS)) u_user (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en & ~hdr_sel), .idx(idx),
      .wdata(cfg_wdata), .be_n(cfg_be_n), .rdata(usr_rdata));

   assign cfg_rdata = hdr_sel ? hdr_rdata : usr_rdata;

   // R1: a claim is only ever raised inside an address phase
   assert_claim_in_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_claim |-> cfg_addr_valid);
endmodule

// File: tb/cfg_space_regs_test.sv
module cfg_space_regs_test;
   localparam int SZ = 12;
   localparam logic [31:0] BMASK = ~((32'd1 << SZ) - 32'd1);

   logic        clk = 0, rst_n = 0;
   logic        cfg_addr_valid = 0, cfg_idsel = 0, cfg_dat_valid = 0;
   logic [3:0]  cfg_cmd = 0, cfg_be_n = 4'hF;
   logic [7:0]  cfg_addr = 0;
   logic [31:0] cfg_wdata = 0;
   logic        cfg_claim, mem_en, perr_en;
   logic [31:0] cfg_rdata, bar_base;

   int vectors = 0, errors = 0;
   bit done = 0;
   logic [31:0] mdl [64];

   always #2 clk = ~clk;

   cfg_space_regs uut (.*);

   function automatic logic [31:0] wmask(input int i);
      if (i == 1) return 32'h0000_0042;
      if (i == 4) return BMASK;
      if (i == 15) return 32'h0000_00FF;
      if (i >= 16) return 32'hFFFF_FFFF;
      return 32'h0;
   endfunction

   function automatic logic [31:0] lanes(input logic [3:0] b);
      return {b[3] ? 8'h0 : 8'hFF, b[2] ? 8'h0 : 8'hFF, b[1] ? 8'h0 : 8'hFF, b[0] ? 8'h0 : 8'hFF};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 64; i++) mdl[i] = 32'h0;
      mdl[0]  = {16'h3C4D, 16'h1A2B};
      mdl[2]  = {24'h0B4000, 8'h05};
      mdl[3]  = 32'h0;
      mdl[15] = {16'h0, 8'h01, 8'h00};
   endtask

   task automatic cyc(input bit sel, input logic [3:0] cmd, input logic [7:0] a,
                      input logic [3:0] be, input logic [31:0] wd, input string req);
      bit claim_exp;
      int i;
      logic [31:0] m;
      claim_exp = sel && (cmd == 4'b1010 || cmd == 4'b1011) && a[1:0] == 2'b00;
      i = int'(a[7:2]);
      @(negedge clk);
      cfg_addr_valid = 1; cfg_idsel = sel; cfg_cmd = cmd; cfg_addr = a;
      #1 chk({req, " R1 claim"}, 32'(cfg_claim), 32'(claim_exp));
      @(negedge clk);
      cfg_addr_valid = 0; cfg_idsel = 0; cfg_dat_valid = 1; cfg_wdata = wd; cfg_be_n = be;
      #1 if (claim_exp) chk({req, " R11 rdata"}, cfg_rdata, mdl[i]);
      @(negedge clk);
      cfg_dat_valid = 0; cfg_be_n = 4'hF;
      if (claim_exp && cmd == 4'b1011) begin
         m = wmask(i) & lanes(be);
         mdl[i] = (mdl[i] & ~m) | (wd & m);
      end
      #1;
      chk({req, " R6 bar_base"}, bar_base, mdl[4]);
      chk({req, " R7 enables"}, {30'd0, perr_en, mem_en}, {30'd0, mdl[1][6], mdl[1][1]});
   endtask

   task automatic rd(input logic [7:0] a, input string req);
      cyc(1, 4'b1010, a, 4'h0, $urandom, req);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R9 reset state, R4 fixed fields, R3 full map
      for (int w = 0; w < 64; w++) rd(8'(w << 2), "R9 R4 reset readback");

      // R6 sizing: all ones reads back mask
      cyc(1, 4'b1011, 8'h10, 4'h0, 32'hFFFF_FFFF, "R6 size write");
      rd(8'h10, "R6 size read");
      chk("R6 mask value", bar_base, 32'hFFFF_F000);
      // R5 partial lanes on BAR
      cyc(1, 4'b1011, 8'h10, 4'b1010, 32'h1234_5678, "R5 bar lanes");
      rd(8'h10, "R5 bar lanes read");
      // R7 command bits
      cyc(1, 4'b1011, 8'h04, 4'h0, 32'hFFFF_FFFF, "R7 cmd all ones");
      rd(8'h04, "R7 cmd read");
      cyc(1, 4'b1011, 8'h04, 4'b0001, 32'h0, "R5 cmd lane off");
      // R4 / R8 read-only writes
      cyc(1, 4'b1011, 8'h00, 4'h0, 32'h0, "R4 ident write");
      rd(8'h00, "R4 ident read");
      cyc(1, 4'b1011, 8'h08, 4'h0, 32'hFFFF_FFFF, "R4 class write");
      rd(8'h08, "R4 class read");
      cyc(1, 4'b1011, 8'h3C, 4'h0, 32'hFFFF_FFFF, "R8 intr write");
      rd(8'h3C, "R8 intr read");
      cyc(1, 4'b1011, 8'h14, 4'h0, 32'hFFFF_FFFF, "R8 reserved write");
      rd(8'h14, "R8 reserved read");
      // R2 type-1, idsel low, wrong command
      cyc(1, 4'b1011, 8'h41, 4'h0, 32'hDEAD_BEEF, "R2 type1");
      rd(8'h40, "R2 type1 read");
      cyc(0, 4'b1011, 8'h40, 4'h0, 32'hDEAD_BEEF, "R2 idsel low");
      rd(8'h40, "R2 idsel read");
      cyc(1, 4'b0111, 8'h10, 4'h0, 32'h0, "R2 mem write cmd");
      // R10 read data strobe writes nothing
      cyc(1, 4'b1010, 8'h10, 4'h0, 32'h0, "R10 read strobe");
      // R3 user storage edges
      cyc(1, 4'b1011, 8'h40, 4'h0, 32'hA5A5_0001, "R3 first user");
      cyc(1, 4'b1011, 8'hFC, 4'b0110, 32'h5A5A_0002, "R3 last user");
      rd(8'h40, "R3 first read");
      rd(8'hFC, "R3 last read");

      for (int n = 0; n < 600; n++) begin
         logic [3:0] c;
         logic [7:0] a;
         c = ($urandom % 4 == 0) ? 4'($urandom) : (($urandom % 2) ? 4'b1011 : 4'b1010);
         a = 8'($urandom);
         if ($urandom % 5 != 0) a[1:0] = 2'b00;
         cyc(($urandom % 8) != 0, c, a, 4'($urandom), $urandom, "R5 random");
      end
      for (int w = 0; w < 64; w++) rd(8'(w << 2), "R3 final sweep");

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule